// File: doc/BRIEF.md
# Accumulator ALU with Condition Flags

This block is the arithmetic and logic unit of a small accumulator processor. It is purely combinational: in the same cycle it takes a 5-bit operation code, two operands, and the current condition flags, and it returns a result, a new set of flags (half-carry, negative, zero, overflow, carry) and a write-enable. The write-enable tells the register file whether to store the result. Compare and bit-test set the flags but store nothing.

Byte operations use the low eight bits of each operand and return a result whose upper byte is zero. A separate 16-bit path adds, subtracts and compares the full operands. Flags that an operation does not define keep their incoming values, so a flag register can load `flagsOut` on every executed instruction.

Top module: `acc_alu`

## Requirements
- R1: ADD (code 0) and ADC (code 1) return (a+b+cin) mod 256. ADC uses the incoming C as cin; ADD uses 0. C is set when the unsigned sum exceeds 255. V is set when the signed sum lies outside -128..+127. Examples: 0x56+0xB0 gives 0x06 with C=1 and V=0; 0x56+0x60 gives 0xB6 with C=0 and V=1.
- R2: H is set on ADD and ADC when the low nibbles plus cin exceed 15. Every other operation passes the incoming H through unchanged.
- R3: SUB (code 2) and SBC (code 3) return (a-b-cin) mod 256. SBC uses the incoming C as cin. C is the borrow, set when a-b-cin is negative. V is set when the signed difference lies outside -128..+127.
- R4: CMP (code 4) sets N, Z, V and C exactly as SUB does, and holds writeEn low. Code 20 does the same for the 16-bit subtract.
- R5: The flag port is ordered {H,N,Z,V,C}, bits 4 down to 0. On every defined operation, N is the top bit of the result at the operation's width and Z is set when that result is zero. Byte operations drive result bits 15:8 to zero.
- R6: AND (5), OR (6) and XOR (7) clear V and keep C. COM (9) returns the inverse of a, clears V and sets C. CLR (10) returns 0 with N=0, Z=1, V=0 and C=0. All five assert writeEn.
- R7: BIT (8) forms a AND b, takes N and Z from that value, clears V, keeps C, and holds writeEn low.
- R8: INC (11) and DEC (12) wrap modulo 256 and keep C. V is set only when INC goes from 0x7F to 0x80 or DEC goes from 0x80 to 0x7F.
- R9: LSL (13), LSR (14) and ASR (15) shift a by one bit. C receives the bit shifted out. LSR fills with 0. ASR keeps the sign bit. V = N xor C.
- R10: ROL (16) and ROR (17) rotate the nine bits made of a and C by one place, with V = N xor C. Nine rotates in the same direction restore both a and C.
- R11: ADDW (18), SUBW (19) and CMPW (20) work on all 16 bits. C is the carry or borrow out of bit 15. V is signed 16-bit overflow. N is bit 15. Z covers all 16 bits. H is kept. CMPW holds writeEn low.
- R12: Codes 21 to 31 return result 0, leave every flag unchanged, and hold writeEn low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opCode | input | 5 | Operation code (see requirements) |
| opA | input | 16 | First operand; low byte for byte operations |
| opB | input | 16 | Second operand; low byte for byte operations |
| flagsIn | input | 5 | Current flags {H,N,Z,V,C} |
| result | output | 16 | Operation result |
| flagsOut | output | 5 | Updated flags {H,N,Z,V,C} |
| writeEn | output | 1 | High when the result is to be stored |

## Verification
In one evaluation, flag generation and write suppression coincide: compare and bit-test must produce full, correct flags while holding the write-enable low. A second coincidence is the incoming carry being consumed and replaced in the same operation, as in add-with-carry, subtract-with-borrow and the rotates.

The bench drives operand pairs that sit on the signed and unsigned boundaries with both carry-in values. It also chains nine rotates through the carry. Each evaluation is checked against a behavioural integer model: result, every flag and the write-enable together.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,  OP_ADC  = 5'd1,  OP_SUB  = 5'd2,  OP_SBC  = 5'd3,
    OP_CMP  = 5'd4,  OP_AND  = 5'd5,  OP_OR   = 5'd6,  OP_XOR  = 5'd7,
    OP_BIT  = 5'd8,  OP_COM  = 5'd9,  OP_CLR  = 5'd10, OP_INC  = 5'd11,
    OP_DEC  = 5'd12, OP_LSL  = 5'd13, OP_LSR  = 5'd14, OP_ASR  = 5'd15,
    OP_ROL  = 5'd16, OP_ROR  = 5'd17, OP_ADDW = 5'd18, OP_SUBW = 5'd19,
    OP_CMPW = 5'd20
  } aluOp_e;

  typedef enum logic [1:0] {
    UNIT_ARITH = 2'd0, UNIT_LOGIC = 2'd1, UNIT_SHIFT = 2'd2, UNIT_NONE = 2'd3
  } unit_e;

  typedef enum logic [2:0] {
    LG_AND = 3'd0, LG_OR = 3'd1, LG_XOR = 3'd2, LG_COM = 3'd3, LG_CLR = 3'd4
  } logicSel_e;

  typedef enum logic [2:0] {
    SH_LSL = 3'd0, SH_LSR = 3'd1, SH_ASR = 3'd2, SH_ROL = 3'd3, SH_ROR = 3'd4
  } shiftSel_e;

  // Strobes from decode to datapath
  typedef struct packed {
    unit_e     unit;
    logic      sub;
    logic      useCarry;
    logic      bOne;
    logic      keepC;
    logic      wide;
    logic      updH;
    logic      writeRes;
    logicSel_e lsel;
    shiftSel_e ssel;
  } aluCtrl_t;

  typedef struct packed {
    logic h;
    logic n;
    logic z;
    logic v;
    logic c;
  } aluFlags_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [4:0] opCode,
  output aluCtrl_t   ctrl
);

  always_comb begin
    ctrl      = '0;
    ctrl.unit = UNIT_NONE;
    case (opCode)
      OP_ADD:  begin ctrl.unit = UNIT_ARITH; ctrl.updH = 1'b1; ctrl.writeRes = 1'b1; end
      OP_ADC:  begin ctrl.unit = UNIT_ARITH; ctrl.updH = 1'b1; ctrl.useCarry = 1'b1; ctrl.writeRes = 1'b1; end
      OP_SUB:  begin ctrl.unit = UNIT_ARITH; ctrl.sub = 1'b1; ctrl.writeRes = 1'b1; end
      OP_SBC:  begin ctrl.unit = UNIT_ARITH; ctrl.sub = 1'b1; ctrl.useCarry = 1'b1; ctrl.writeRes = 1'b1; end
      OP_CMP:  begin ctrl.unit = UNIT_ARITH; ctrl.sub = 1'b1; end
      OP_AND:  begin ctrl.unit = UNIT_LOGIC; ctrl.lsel = LG_AND; ctrl.writeRes = 1'b1; end
      OP_OR:   begin ctrl.unit = UNIT_LOGIC; ctrl.lsel = LG_OR;  ctrl.writeRes = 1'b1; end
      OP_XOR:  begin ctrl.unit = UNIT_LOGIC; ctrl.lsel = LG_XOR; ctrl.writeRes = 1'b1; end
      OP_BIT:  begin ctrl.unit = UNIT_LOGIC; ctrl.lsel = LG_AND; end
      OP_COM:  begin ctrl.unit = UNIT_LOGIC; ctrl.lsel = LG_COM; ctrl.writeRes = 1'b1; end
      OP_CLR:  begin ctrl.unit = UNIT_LOGIC; ctrl.lsel = LG_CLR; ctrl.writeRes = 1'b1; end
      OP_INC:  begin ctrl.unit = UNIT_ARITH; ctrl.bOne = 1'b1; ctrl.keepC = 1'b1; ctrl.writeRes = 1'b1; end
      OP_DEC:  begin ctrl.unit = UNIT_ARITH; ctrl.sub = 1'b1; ctrl.bOne = 1'b1; ctrl.keepC = 1'b1; ctrl.writeRes = 1'b1; end
      OP_LSL:  begin ctrl.unit = UNIT_SHIFT; ctrl.ssel = SH_LSL; ctrl.writeRes = 1'b1; end
      OP_LSR:  begin ctrl.unit = UNIT_SHIFT; ctrl.ssel = SH_LSR; ctrl.writeRes = 1'b1; end
      OP_ASR:  begin ctrl.unit = UNIT_SHIFT; ctrl.ssel = SH_ASR; ctrl.writeRes = 1'b1; end
      OP_ROL:  begin ctrl.unit = UNIT_SHIFT; ctrl.ssel = SH_ROL; ctrl.writeRes = 1'b1; end
      OP_ROR:  begin ctrl.unit = UNIT_SHIFT; ctrl.ssel = SH_ROR; ctrl.writeRes = 1'b1; end
      OP_ADDW: begin ctrl.unit = UNIT_ARITH; ctrl.wide = 1'b1; ctrl.writeRes = 1'b1; end
      OP_SUBW: begin ctrl.unit = UNIT_ARITH; ctrl.wide = 1'b1; ctrl.sub = 1'b1; ctrl.writeRes = 1'b1; end
      OP_CMPW: begin ctrl.unit = UNIT_ARITH; ctrl.wide = 1'b1; ctrl.sub = 1'b1; end
      default: ctrl.unit = UNIT_NONE;
    endcase
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  aluCtrl_t              ctrl,
  input  logic [2*DATA_W-1:0]   opA,
  input  logic [2*DATA_W-1:0]   opB,
  input  aluFlags_t             flagsIn,
  output logic [2*DATA_W-1:0]   result,
  output aluFlags_t             flagsOut
);

  localparam int WW  = 2 * DATA_W;
  localparam int HB  = DATA_W / 2;
  localparam int MSB = DATA_W - 1;

  logic [WW-1:0]     bEff;
  logic              cin;
  logic [WW:0]       wideSum, wideDiff;
  logic [DATA_W:0]   narSum, narDiff;
  logic [HB:0]       nibSum;
  logic [DATA_W-1:0] a8, b8, r8;
  logic [WW-1:0]     r16;
  logic              cNew, vNew;
  aluFlags_t         f;

  assign bEff = ctrl.bOne ? WW'(1) : opB;
  assign cin  = ctrl.useCarry & flagsIn.c;
  assign a8   = opA[DATA_W-1:0];
  assign b8   = bEff[DATA_W-1:0];

  always_comb begin
    wideSum  = {1'b0, opA} + {1'b0, bEff} + {{WW{1'b0}}, cin};
    wideDiff = {1'b0, opA} - {1'b0, bEff} - {{WW{1'b0}}, cin};
    narSum   = {1'b0, a8} + {1'b0, b8} + {{DATA_W{1'b0}}, cin};
    narDiff  = {1'b0, a8} - {1'b0, b8} - {{DATA_W{1'b0}}, cin};
    nibSum   = {1'b0, a8[HB-1:0]} + {1'b0, b8[HB-1:0]} + {{HB{1'b0}}, cin};
  end

  always_comb begin
    r8   = '0;
    r16  = '0;
    f    = flagsIn;
    cNew = flagsIn.c;
    vNew = 1'b0;
    case (ctrl.unit)
      UNIT_ARITH: begin
        if (ctrl.wide) begin
          r16  = ctrl.sub ? wideDiff[WW-1:0] : wideSum[WW-1:0];
          cNew = ctrl.sub ? wideDiff[WW] : wideSum[WW];
          vNew = ctrl.sub ? ((opA[WW-1] ^ bEff[WW-1]) & (opA[WW-1] ^ r16[WW-1]))
                          : (~(opA[WW-1] ^ bEff[WW-1]) & (opA[WW-1] ^ r16[WW-1]));
        end else begin
          r8   = ctrl.sub ? narDiff[DATA_W-1:0] : narSum[DATA_W-1:0];
          cNew = ctrl.sub ? narDiff[DATA_W] : narSum[DATA_W];
          vNew = ctrl.sub ? ((a8[MSB] ^ b8[MSB]) & (a8[MSB] ^ r8[MSB]))
                          : (~(a8[MSB] ^ b8[MSB]) & (a8[MSB] ^ r8[MSB]));
        end
        if (ctrl.keepC) cNew = flagsIn.c;
        if (ctrl.updH)  f.h  = nibSum[HB];
      end
      UNIT_LOGIC: begin
        case (ctrl.lsel)
          LG_AND:  r8 = a8 & b8;
          LG_OR:   r8 = a8 | b8;
          LG_XOR:  r8 = a8 ^ b8;
          LG_COM:  begin r8 = ~a8; cNew = 1'b1; end
          LG_CLR:  begin r8 = '0;  cNew = 1'b0; end
          default: r8 = '0;
        endcase
      end
      UNIT_SHIFT: begin
        case (ctrl.ssel)
          SH_LSL:  {cNew, r8} = {a8, 1'b0};
          SH_LSR:  {r8, cNew} = {1'b0, a8};
          SH_ASR:  {r8, cNew} = {a8[MSB], a8};
          SH_ROL:  {cNew, r8} = {a8, flagsIn.c};
          SH_ROR:  {r8, cNew} = {flagsIn.c, a8};
          default: {cNew, r8} = {flagsIn.c, a8};
        endcase
        vNew = r8[MSB] ^ cNew;
      end
      default: ;
    endcase
    if (ctrl.unit != UNIT_NONE) begin
      if (ctrl.wide) begin
        f.n = r16[WW-1];
        f.z = (r16 == '0);
      end else begin
        f.n = r8[MSB];
        f.z = (r8 == '0);
      end
      f.v = vNew;
      f.c = cNew;
    end
  end

  assign result   = ctrl.wide ? r16 : {{DATA_W{1'b0}}, r8};
  assign flagsOut = f;

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [4:0]          opCode,
  input  logic [2*DATA_W-1:0] opA,
  input  logic [2*DATA_W-1:0] opB,
  input  logic [4:0]          flagsIn,
  output logic [2*DATA_W-1:0] result,
  output logic [4:0]          flagsOut,
  output logic                writeEn
);

  aluCtrl_t  ctrl;
  aluFlags_t fOut;

  alu_ctrl u_ctrl (
    .opCode (opCode),
    .ctrl   (ctrl)
  );

  alu_datapath #(.DATA_W(DATA_W)) u_dp (
    .ctrl     (ctrl),
    .opA      (opA),
    .opB      (opB),
    .flagsIn  (aluFlags_t'(flagsIn)),
    .result   (result),
    .flagsOut (fOut)
  );

  assign flagsOut = fOut;
  assign writeEn  = ctrl.writeRes;

endmodule

// File: rtl/acc_alu_checker.sv
module acc_alu_checker
  import alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic [4:0]          opCode,
  input logic [2*DATA_W-1:0] opA,
  input logic [2*DATA_W-1:0] opB,
  input logic [4:0]          flagsIn,
  input logic [2*DATA_W-1:0] result,
  input logic [4:0]          flagsOut,
  input logic                writeEn
);

  localparam int WW = 2 * DATA_W;

  always_comb begin
    if (!$isunknown({opCode, opA, opB, flagsIn})) begin
      // R1: byte add gives carry and sum together
      if (opCode == OP_ADD)
        p_add_sum_r1: assert ({flagsOut[0], result[DATA_W-1:0]} ==
                              {1'b0, opA[DATA_W-1:0]} + {1'b0, opB[DATA_W-1:0]})
          else $error("add sum/carry mismatch");
      // R4: compare stores nothing
      if (opCode == OP_CMP || opCode == OP_CMPW)
        p_cmp_nowrite_r4: assert (!writeEn) else $error("compare wrote");
      // R5: zero flag tracks the full result on defined operations
      if (opCode <= OP_CMPW)
        p_zero_flag_r5: assert (flagsOut[2] == (result == '0)) else $error("Z mismatch");
      // R7: bit test clears V, keeps C, stores nothing
      if (opCode == OP_BIT)
        p_bit_flags_r7: assert (!flagsOut[1] && flagsOut[0] == flagsIn[0] && !writeEn)
          else $error("bit test flags");
      // R8: increment and decrement keep carry
      if (opCode == OP_INC || opCode == OP_DEC)
        p_incdec_keepc_r8: assert (flagsOut[0] == flagsIn[0]) else $error("inc/dec touched C");
      // R9: shifts and rotates set V from N and C
      if (opCode >= OP_LSL && opCode <= OP_ROR)
        p_shift_v_r9: assert (flagsOut[1] == (flagsOut[3] ^ flagsOut[0])) else $error("shift V");
      // R11: wide add gives carry and sum together
      if (opCode == OP_ADDW)
        p_wide_sum_r11: assert ({flagsOut[0], result} == {1'b0, opA} + {1'b0, opB})
          else $error("wide add mismatch");
      if (opCode == OP_ADDW || opCode == OP_SUBW || opCode == OP_CMPW)
        p_wide_neg_r11: assert (flagsOut[3] == result[WW-1]) else $error("wide N");
      // R12: undefined codes are inert
      if (opCode > OP_CMPW)
        p_undef_inert_r12: assert (flagsOut == flagsIn && !writeEn && result == '0)
          else $error("undefined op not inert");
    end
  end

endmodule

bind acc_alu acc_alu_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/acc_alu_test.sv
`timescale 1ns/1ps
module acc_alu_test;

  logic        clk = 1'b0;
  logic [4:0]  opCode = '0;
  logic [15:0] opA = '0, opB = '0;
  logic [4:0]  flagsIn = '0;
  logic [15:0] result;
  logic [4:0]  flagsOut;
  logic        writeEn;

  int nTests = 0, nFail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  acc_alu uut (
    .opCode(opCode), .opA(opA), .opB(opB), .flagsIn(flagsIn),
    .result(result), .flagsOut(flagsOut), .writeEn(writeEn)
  );

  // Behavioural model: returns {we, flags{H,N,Z,V,C}, result}
  function automatic logic [21:0] model(int op, int a, int b, logic [4:0] fi);
    int r, s, a8, b8, ci, sa, sb, sa16, sb16;
    logic h, n, z, v, c, we, wide;
    a8 = a % 256; b8 = b % 256; ci = fi[0];
    sa = (a8 >= 128) ? a8 - 256 : a8;
    sb = (b8 >= 128) ? b8 - 256 : b8;
    sa16 = (a >= 32768) ? a - 65536 : a;
    sb16 = (b >= 32768) ? b - 65536 : b;
    {h, n, z, v, c} = fi;
    we = 1'b1; wide = 1'b0; r = 0;
    case (op)
      0, 1: begin
        s = (op == 1) ? ci : 0;
        r = a8 + b8 + s; c = (r > 255);
        v = ((sa + sb + s) > 127) || ((sa + sb + s) < -128);
        h = ((a8 % 16) + (b8 % 16) + s) > 15;
        r = r % 256;
      end
      2, 3, 4: begin
        s = (op == 3) ? ci : 0;
        r = a8 - b8 - s; c = (r < 0);
        v = ((sa - sb - s) > 127) || ((sa - sb - s) < -128);
        r = (r + 512) % 256; we = (op != 4);
      end
      5, 8: begin r = a8 & b8; v = 0; we = (op == 5); end
      6: begin r = a8 | b8; v = 0; end
      7: begin r = a8 ^ b8; v = 0; end
      9: begin r = 255 - a8; v = 0; c = 1; end
      10: begin r = 0; v = 0; c = 0; end
      11: begin r = (a8 + 1) % 256; v = (a8 == 127); end
      12: begin r = (a8 + 255) % 256; v = (a8 == 128); end
      13: begin c = (a8 >= 128); r = (a8 * 2) % 256; end
      14: begin c = a8 % 2; r = a8 / 2; end
      15: begin c = a8 % 2; r = a8 / 2 + ((a8 >= 128) ? 128 : 0); end
      16: begin c = (a8 >= 128); r = (a8 * 2) % 256 + ci; end
      17: begin c = a8 % 2; r = a8 / 2 + ci * 128; end
      18: begin
        wide = 1; r = a + b; c = (r > 65535);
        v = ((sa16 + sb16) > 32767) || ((sa16 + sb16) < -32768); r = r % 65536;
      end
      19, 20: begin
        wide = 1; r = a - b; c = (r < 0);
        v = ((sa16 - sb16) > 32767) || ((sa16 - sb16) < -32768);
        r = (r + 131072) % 65536; we = (op != 20);
      end
      default: return {1'b0, fi, 16'h0000};
    endcase
    n = wide ? (r >= 32768) : (r >= 128);
    z = (r == 0);
    if (op >= 13 && op <= 17) v = n ^ c;
    return {we, h, n, z, v, c, 16'(r)};
  endfunction

  function automatic string reqOf(int op);
    case (op)
      0, 1: return "R1";
      2, 3: return "R3";
      4: return "R4";
      5, 6, 7, 9, 10: return "R6";
      8: return "R7";
      11, 12: return "R8";
      13, 14, 15: return "R9";
      16, 17: return "R10";
      18, 19, 20: return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic run(int op, int a, int b, logic [4:0] fi, string tag);
    logic [21:0] exp;
    @(posedge clk); #1;
    opCode = 5'(op); opA = 16'(a); opB = 16'(b); flagsIn = fi;
    exp = model(op, a, b, fi);
    @(negedge clk);
    nTests++;
    if ({writeEn, flagsOut, result} !== exp) begin
      nFail++;
      $display("FAIL %s op=%0d a=%h b=%h fi=%b: got we=%b f=%b r=%h, expected we=%b f=%b r=%h",
               tag, op, a, b, fi, writeEn, flagsOut, result, exp[21], exp[20:16], exp[15:0]);
    end
  endtask

  task automatic expectEq(logic [31:0] got, logic [31:0] want, string tag);
    nTests++;
    if (got !== want) begin
      nFail++;
      $display("FAIL %s: got %h, expected %h", tag, got, want);
    end
  endtask

  initial begin
    logic [7:0] rv;
    logic       rc;
    // initial input state: ADD of zeros
    run(0, 0, 0, 5'b00000, "R5");
    // R1 signed/unsigned boundary examples
    run(0, 'h56, 'hB0, 5'b00000, "R1");
    expectEq({result, flagsOut[1:0]}, {16'h0006, 2'b01}, "R1");
    run(0, 'h56, 'h60, 5'b00000, "R1");
    expectEq({result, flagsOut[1:0]}, {16'h00B6, 2'b10}, "R1");
    run(1, 'hFF, 'h00, 5'b00001, "R1");
    run(1, 'h7F, 'h00, 5'b00001, "R1");
    run(0, 'h7F, 'h7F, 5'b00001, "R1");
    // R2 half carry
    run(0, 'h08, 'h08, 5'b00000, "R2");
    run(1, 'h0F, 'h00, 5'b00001, "R2");
    run(2, 'h08, 'h08, 5'b10000, "R2");
    run(6, 'h0F, 'h01, 5'b10000, "R2");
    // R3 subtract / borrow
    run(2, 'h10, 'h20, 5'b00000, "R3");
    run(3, 'h00, 'h00, 5'b00001, "R3");
    run(2, 'h80, 'h01, 5'b00000, "R3");
    run(3, 'h50, 'h10, 5'b00000, "R3");
    // R4 compare
    run(4, 'h50, 'h51, 5'b00000, "R4");
    run(4, 'h42, 'h42, 5'b00001, "R4");
    // R5 zero/negative with upper operand bytes set
    run(0, 'hFF80, 'hAA80, 5'b00000, "R5");
    run(6, 'h1280, 'h3400, 5'b00000, "R5");
    // R6 logic
    run(5, 'hF0, 'h3C, 5'b00011, "R6");
    run(6, 'h00, 'h00, 5'b00011, "R6");
    run(7, 'hAA, 'hFF, 5'b00010, "R6");
    run(9, 'h0F, 'h00, 5'b00010, "R6");
    run(10, 'h99, 'h77, 5'b11111, "R6");
    // R7 bit test
    run(8, 'h3F, 'h03, 5'b00011, "R7");
    run(8, 'h05, 'h1A, 5'b00010, "R7");
    run(8, 'h80, 'hFF, 5'b00000, "R7");
    // R8 inc/dec
    run(11, 'h7F, 0, 5'b00001, "R8");
    run(11, 'hFF, 0, 5'b00000, "R8");
    run(12, 'h80, 0, 5'b00001, "R8");
    run(12, 'h00, 0, 5'b00000, "R8");
    // R9 shifts
    run(13, 'hC1, 0, 5'b00000, "R9");
    run(14, 'h81, 0, 5'b00000, "R9");
    run(15, 'h81, 0, 5'b00000, "R9");
    run(15, 'h40, 0, 5'b00001, "R9");
    // R10 rotates through carry
    run(16, 'h3B, 0, 5'b00001, "R10");
    run(17, 'h3B, 0, 5'b00001, "R10");
    rv = 8'h3B; rc = 1'b1;
    for (int k = 0; k < 9; k++) begin
      run(16, rv, 0, {4'b0000, rc}, "R10");
      rv = result[7:0]; rc = flagsOut[0];
    end
    expectEq({23'd0, rc, rv}, {23'd0, 1'b1, 8'h3B}, "R10 nine ROL");
    rv = 8'hA4; rc = 1'b0;
    for (int k = 0; k < 9; k++) begin
      run(17, rv, 0, {4'b0000, rc}, "R10");
      rv = result[7:0]; rc = flagsOut[0];
    end
    expectEq({23'd0, rc, rv}, {23'd0, 1'b0, 8'hA4}, "R10 nine ROR");
    // R11 16-bit path
    run(18, 'hFFFF, 'h0001, 5'b10000, "R11");
    run(18, 'h7FFF, 'h0001, 5'b00000, "R11");
    run(19, 'h0000, 'h0001, 5'b00000, "R11");
    run(19, 'h8000, 'h0001, 5'b00000, "R11");
    run(20, 'h5100, 'h5100, 5'b00000, "R11");
    run(18, 'h0100, 'h0000, 5'b00000, "R11");
    // R12 undefined codes
    run(21, 'h12, 'h34, 5'b10101, "R12");
    run(31, 'hFF, 'hFF, 5'b01010, "R12");
    // mixed patterns across all codes
    for (int k = 0; k < 600; k++) begin
      int op = $urandom_range(0, 23);
      run(op, $urandom_range(0, 65535), $urandom_range(0, 65535),
          5'($urandom_range(0, 31)), reqOf(op));
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule